// File: doc/BRIEF.md
# Indirect Register-to-Peripheral-Bus Access Bridge

This block is a slave register file on a 64-bit register bus. Software uses it to make indirect reads and writes on a downstream byte-addressed peripheral bus. The register bus offset is the incoming byte address with its three low bits dropped. A command register holds a direction flag, a transfer size and a 32-bit target address. A data register holds the doubleword that is moved.

Storing a command with the read flag set starts a downstream read at once. Storing data while the command selects a write starts a downstream write. Data smaller than a doubleword sits at its natural byte lane inside an 8-byte sector and is not right-justified.

Only one downstream transaction can be outstanding. While it runs, the block raises `busy` and withholds its register-bus acknowledge until the downstream side acknowledges. A status register reports done. Several offsets are accepted silently. Any other offset reads as zero, discards writes and pulses a debug strobe.

Top module: `lpcb_bridge`

## Requirements
- R1: After reset the command and data registers read as zero, `busy` and `dn_req` are low, and no acknowledge is pending.
- R2: A write to offset 0x41 stores the command. Bit 63 is the read flag, bits 58:52 are the byte size and bits 31:0 are the target address. With bit 63 clear, the write starts no transaction and is acknowledged one cycle after the request. The stored value reads back from 0x41.
- R3: A command write with bit 63 set raises `dn_req` and `busy` in the next cycle, with `dn_we`=0, `dn_addr`=bits 31:0 and `dn_size`=bits 58:52. These outputs stay stable until `dn_ack`. The register acknowledge is withheld until `dn_ack`.
- R4: A downstream read loads the data register as follows. Let o = address & 7 and n = the size. Byte lane k (lane 0 is bits 63:56) for o ≤ k < min(o+n, 8) receives downstream byte k−o. Downstream byte 0 is `dn_rdata[63:56]`. Every other lane is cleared to zero.
- R5: A write to offset 0x42 stores the data. If the stored command has bit 63 clear, a downstream write starts with `dn_we`=1, the command's address and size, and `dn_wdata` equal to the data shifted toward the most significant end by (address & 7)×8 bits. The register acknowledge follows `dn_ack`.
- R6: A data write while the stored command has bit 63 set only stores the data. No transaction starts, and the acknowledge comes one cycle later.
- R7: Reading offset 0x43 returns 0x8000_0000_0000_0000 when idle. Writes to 0x43 change nothing. `busy` is high from the launch until the cycle in which the acknowledge is returned, and no acknowledge is given while it is high.
- R8: Offsets 0x40, 0x12, 0x13 and 0x18 read as zero and discard writes, without the debug strobe.
- R9: Any other offset reads as zero and discards writes. `reg_unimp` pulses together with its acknowledge.
- R10: After a downstream acknowledge, `reg_ack` rises in the next cycle and `dn_req` drops in that same cycle. Even when the downstream side acknowledges in the first cycle of the request, the transaction completes this way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | One-cycle register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 32 | Byte address of the access |
| reg_wdata | input | 64 | Write data |
| reg_ack | output | 1 | One-cycle response strobe |
| reg_rdata | output | 64 | Read data, valid with reg_ack |
| reg_unimp | output | 1 | Debug pulse for an unmapped offset |
| busy | output | 1 | Downstream transaction outstanding |
| dn_req | output | 1 | Downstream request, held until dn_ack |
| dn_we | output | 1 | Downstream direction, 1 = write |
| dn_addr | output | 32 | Downstream byte address |
| dn_size | output | 7 | Downstream size in bytes |
| dn_wdata | output | 64 | Downstream write data, first byte in bits 63:56 |
| dn_ack | input | 1 | Downstream completion strobe |
| dn_rdata | input | 64 | Downstream read data, first byte in bits 63:56, valid with dn_ack |

## Verification
The hardest cases to reach are lane clipping and lane clearing on a read. These occur when the size runs past the end of the 8-byte sector, or when the data register already holds non-zero bytes that the read must wipe. The stimulus first fills the data register with a known pattern, then issues reads at offsets 5, 6 and 0 with sizes 1, 4 and 8. A second tricky case is a downstream acknowledge in the first request cycle. The downstream responder model is told per transaction to answer with zero delay or after several cycles.

// File: rtl/lpcb_pkg.sv
package lpcb_pkg;
    localparam int unsigned DATA_W   = 64;
    localparam int unsigned TADDR_W  = 32;
    localparam int unsigned SIZE_W   = 7;
    localparam int unsigned SIZE_LSB = 52;
    localparam int unsigned RD_BIT   = 63;

    localparam logic [7:0] OFF_BASE  = 8'h40;
    localparam logic [7:0] OFF_CMD   = 8'h41;
    localparam logic [7:0] OFF_DATA  = 8'h42;
    localparam logic [7:0] OFF_STAT  = 8'h43;
    localparam logic [7:0] OFF_LOG   = 8'h12;
    localparam logic [7:0] OFF_ERR   = 8'h13;
    localparam logic [7:0] OFF_RXST  = 8'h18;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_QUIET,
        SEL_CMD,
        SEL_DATA,
        SEL_STAT
    } sel_e;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } st_e;
endpackage

// File: rtl/lpcb_decode.sv
module lpcb_decode
    import lpcb_pkg::*;
#(
    parameter int unsigned OFF_W = 29
) (
    input  logic [OFF_W-1:0] offset,
    output sel_e             sel
);
    always_comb begin
        sel = SEL_NONE;
        if (offset == OFF_W'(OFF_CMD)) begin
            sel = SEL_CMD;
        end else if (offset == OFF_W'(OFF_DATA)) begin
            sel = SEL_DATA;
        end else if (offset == OFF_W'(OFF_STAT)) begin
            sel = SEL_STAT;
        end else if (offset == OFF_W'(OFF_BASE) || offset == OFF_W'(OFF_LOG) ||
                     offset == OFF_W'(OFF_ERR)  || offset == OFF_W'(OFF_RXST)) begin
            sel = SEL_QUIET;
        end
    end
endmodule

// File: rtl/lpcb_lane.sv
module lpcb_lane #(
    parameter int unsigned DW     = 64,
    parameter int unsigned SIZE_W = 7
) (
    input  logic [$clog2(DW/8)-1:0] lane_off,
    input  logic [SIZE_W-1:0]       size,
    input  logic [DW-1:0]           rd_raw,
    input  logic [DW-1:0]           wr_src,
    output logic [DW-1:0]           rd_aligned,
    output logic [DW-1:0]           wr_aligned
);
    localparam int unsigned NLANE  = DW / 8;
    localparam int unsigned LOFF_W = $clog2(NLANE);
    localparam int unsigned END_W  = SIZE_W + 1;

    logic [DW-1:0]    rd_shift;
    logic [END_W-1:0] end_lane;
    logic [END_W-1:0] start_lane;
    logic [NLANE-1:0] lane_en;

    assign start_lane = END_W'(lane_off);
    assign end_lane   = start_lane + END_W'(size);
    assign rd_shift   = rd_raw >> {lane_off, 3'b000};
    assign wr_aligned = wr_src << {lane_off, 3'b000};

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        localparam logic [END_W-1:0] KIDX = END_W'(k);
        assign lane_en[k] = (KIDX >= start_lane) && (KIDX < end_lane);
        assign rd_aligned[DW-1-8*k -: 8] = lane_en[k] ? rd_shift[DW-1-8*k -: 8] : 8'h00;
    end

    logic unused_loff;
    assign unused_loff = ^{LOFF_W{1'b0}};
endmodule

// File: rtl/lpcb_bridge.sv
module lpcb_bridge
    import lpcb_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_req,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic                reg_ack,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                reg_unimp,
    output logic                busy,
    output logic                dn_req,
    output logic                dn_we,
    output logic [TADDR_W-1:0]  dn_addr,
    output logic [SIZE_W-1:0]   dn_size,
    output logic [DATA_W-1:0]   dn_wdata,
    input  logic                dn_ack,
    input  logic [DATA_W-1:0]   dn_rdata
);
    localparam int unsigned OFF_W  = ADDR_W - 3;
    localparam int unsigned LOFF_W = $clog2(DATA_W / 8);

    typedef struct packed {
        st_e               st;
        logic [DATA_W-1:0] cmd;
        logic [DATA_W-1:0] data;
        logic              ack;
        logic [DATA_W-1:0] rdata;
        logic              unimp;
        logic              dn_we;
    } state_t;

    state_t q, d;
    sel_e   sel;
    logic [DATA_W-1:0] rd_aligned;
    logic [DATA_W-1:0] wr_aligned;

    lpcb_decode #(.OFF_W(OFF_W)) u_decode (
        .offset (reg_addr[ADDR_W-1:3]),
        .sel    (sel)
    );

    lpcb_lane #(.DW(DATA_W), .SIZE_W(SIZE_W)) u_lane (
        .lane_off   (q.cmd[LOFF_W-1:0]),
        .size       (q.cmd[SIZE_LSB +: SIZE_W]),
        .rd_raw     (dn_rdata),
        .wr_src     (q.data),
        .rd_aligned (rd_aligned),
        .wr_aligned (wr_aligned)
    );

    always_comb begin
        d       = q;
        d.ack   = 1'b0;
        d.unimp = 1'b0;
        d.rdata = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (reg_req) begin
                    if (reg_we) begin
                        case (sel)
                            SEL_CMD: begin
                                d.cmd = reg_wdata;
                                if (reg_wdata[RD_BIT]) begin
                                    d.st    = ST_WAIT;
                                    d.dn_we = 1'b0;
                                end else begin
                                    d.ack = 1'b1;
                                end
                            end
                            SEL_DATA: begin
                                d.data = reg_wdata;
                                if (!q.cmd[RD_BIT]) begin
                                    d.st    = ST_WAIT;
                                    d.dn_we = 1'b1;
                                end else begin
                                    d.ack = 1'b1;
                                end
                            end
                            SEL_NONE: begin
                                d.ack   = 1'b1;
                                d.unimp = 1'b1;
                            end
                            default: d.ack = 1'b1;
                        endcase
                    end else begin
                        d.ack = 1'b1;
                        case (sel)
                            SEL_CMD:  d.rdata = q.cmd;
                            SEL_DATA: d.rdata = q.data;
                            SEL_STAT: d.rdata = {1'b1, {(DATA_W-1){1'b0}}};
                            SEL_NONE: d.unimp = 1'b1;
                            default:  d.rdata = '0;
                        endcase
                    end
                end
            end
            ST_WAIT: begin
                if (dn_ack) begin
                    d.st  = ST_IDLE;
                    d.ack = 1'b1;
                    if (!q.dn_we) begin
                        d.data = rd_aligned;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cmd: '0, data: '0, ack: 1'b0,
                   rdata: '0, unimp: 1'b0, dn_we: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign reg_ack   = q.ack;
    assign reg_rdata = q.rdata;
    assign reg_unimp = q.unimp;
    assign dn_req    = (q.st == ST_WAIT);
    assign busy      = dn_req;
    assign dn_we     = q.dn_we;
    assign dn_addr   = q.cmd[TADDR_W-1:0];
    assign dn_size   = q.cmd[SIZE_LSB +: SIZE_W];
    assign dn_wdata  = wr_aligned;

    logic unused_bits;
    assign unused_bits = ^{reg_addr[2:0], q.cmd[SIZE_LSB-1:TADDR_W], q.cmd[RD_BIT-1:SIZE_LSB+SIZE_W]};

    // R3: downstream request held with stable fields until acknowledged
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_ack) |=> (dn_req && $stable(dn_addr) && $stable(dn_size) && $stable(dn_wdata)));

    // R3: a transaction only starts from a register write
    a_r3_launch_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_req && reg_we));

    // R2: command write without read flag answers next cycle, no launch
    a_r2_cmd_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && !busy && sel == SEL_CMD && !reg_wdata[RD_BIT]) |=> (reg_ack && !busy));

    // R6: data write in read mode starts nothing
    a_r6_data_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && !busy && sel == SEL_DATA && q.cmd[RD_BIT]) |=> (reg_ack && !dn_req));

    // R7: no acknowledge while outstanding
    a_r7_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !reg_ack);

    // R9: debug strobe only with an acknowledge
    a_r9_unimp_ack: assert property (@(posedge clk) disable iff (!rst_n)
        reg_unimp |-> reg_ack);

    // R10: completion follows the downstream acknowledge
    a_r10_ack_after_dn: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_ack) |=> (reg_ack && !dn_req));

    // R10: acknowledge is a single-cycle pulse
    a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ack |=> !reg_ack);
endmodule

// File: tb/tb_lpcb_bridge.sv
module tb_lpcb_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic        reg_ack;
    logic [63:0] reg_rdata;
    logic        reg_unimp;
    logic        busy;
    logic        dn_req;
    logic        dn_we;
    logic [31:0] dn_addr;
    logic [6:0]  dn_size;
    logic [63:0] dn_wdata;
    logic        dn_ack = 1'b0;
    logic [63:0] dn_rdata = '0;

    always #5 clk = ~clk;

    lpcb_bridge dut (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
        .reg_rdata(reg_rdata), .reg_unimp(reg_unimp), .busy(busy),
        .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_size(dn_size),
        .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_rdata(dn_rdata)
    );

    typedef struct packed {
        logic [63:0] rdata;
        logic        unimp;
    } resp_t;

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [6:0]  size;
        logic [63:0] wdata;
        logic [63:0] rd;
        logic [3:0]  lat;
    } dn_t;

    resp_t resp_q[$];
    string resp_tag[$];
    dn_t   dn_q[$];
    string dn_tag[$];

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mkcmd(input bit rd, input logic [6:0] size, input logic [31:0] addr);
        return {rd, 4'b0000, size, 20'h00000, addr};
    endfunction

    // model of the lane placement from R4
    function automatic logic [63:0] place(input logic [63:0] raw, input int off, input int n);
        logic [63:0] res = '0;
        for (int k = 0; k < 8; k++) begin
            if (k >= off && k < off + n) begin
                res[63-8*k -: 8] = raw[63-8*(k-off) -: 8];
            end
        end
        return res;
    endfunction

    task automatic expect_dn(input bit we, input logic [31:0] addr, input logic [6:0] size,
                             input logic [63:0] wdata, input logic [63:0] rd, input logic [3:0] lat,
                             input string req);
        dn_q.push_back('{we: we, addr: addr, size: size, wdata: wdata, rd: rd, lat: lat});
        dn_tag.push_back(req);
    endtask

    task automatic access(input bit we, input logic [7:0] off, input logic [63:0] wd,
                          input logic [63:0] exp_rd, input bit exp_unimp, input bit launches,
                          input string req);
        @(negedge clk);
        reg_req   = 1'b1;
        reg_we    = we;
        reg_addr  = {21'h0, off, 3'b000};
        reg_wdata = wd;
        resp_q.push_back('{rdata: exp_rd, unimp: exp_unimp});
        resp_tag.push_back(req);
        @(negedge clk);
        reg_req = 1'b0;
        if (launches) begin
            check(busy && !reg_ack && dn_req, {req, " launch/stall"},
                  {61'h0, busy, reg_ack, dn_req}, 64'h5);
        end else begin
            check(reg_ack && !dn_req && !busy, {req, " one-cycle ack, no launch"},
                  {61'h0, reg_ack, dn_req, busy}, 64'h4);
        end
        while (resp_q.size() != 0) @(negedge clk);
    endtask

    // monitor: pops expected responses as the design acknowledges
    always @(negedge clk) begin
        if (rst_n && reg_ack) begin
            if (resp_q.size() == 0) begin
                check(1'b0, "R10 unexpected ack", 64'h1, 64'h0);
            end else begin
                resp_t e;
                string t;
                e = resp_q.pop_front();
                t = resp_tag.pop_front();
                check(reg_rdata == e.rdata, {t, " rdata"}, reg_rdata, e.rdata);
                check(reg_unimp == e.unimp, {t, " unimp"}, {63'h0, reg_unimp}, {63'h0, e.unimp});
            end
        end
    end

    // downstream responder
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && dn_req) begin
                if (dn_q.size() == 0) begin
                    check(1'b0, "R6 unexpected downstream request", {32'h0, dn_addr}, 64'h0);
                    dn_ack = 1'b1;
                    @(negedge clk);
                    dn_ack = 1'b0;
                end else begin
                    dn_t e;
                    string t;
                    e = dn_q.pop_front();
                    t = dn_tag.pop_front();
                    check(dn_we == e.we, {t, " dn_we"}, {63'h0, dn_we}, {63'h0, e.we});
                    check(dn_addr == e.addr, {t, " dn_addr"}, {32'h0, dn_addr}, {32'h0, e.addr});
                    check(dn_size == e.size, {t, " dn_size"}, {57'h0, dn_size}, {57'h0, e.size});
                    if (e.we) check(dn_wdata == e.wdata, {t, " dn_wdata"}, dn_wdata, e.wdata);
                    repeat (int'(e.lat)) @(negedge clk);
                    dn_ack   = 1'b1;
                    dn_rdata = e.rd;
                    @(negedge clk);
                    dn_ack   = 1'b0;
                    dn_rdata = '0;
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'h0, 64'h1);
        finish_run();
    end

    localparam logic [63:0] D1  = 64'h1122_3344_5566_7788;
    localparam logic [63:0] D2  = 64'hDEAD_BEEF_0BAD_F00D;
    localparam logic [63:0] RAW = 64'hA1B2_C3D4_E5F6_0718;
    localparam logic [63:0] ST_DONE = 64'h8000_0000_0000_0000;

    initial begin
        logic [63:0] c1, c2, c3, c4, c5;
        repeat (3) @(negedge clk);
        check(!busy && !dn_req && !reg_ack, "R1 reset outputs", {61'h0, busy, dn_req, reg_ack}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !dn_req && !reg_ack, "R1 idle after reset", {61'h0, busy, dn_req, reg_ack}, 64'h0);

        access(1'b0, 8'h41, '0, 64'h0, 1'b0, 1'b0, "R1 cmd reset");
        access(1'b0, 8'h42, '0, 64'h0, 1'b0, 1'b0, "R1 data reset");
        access(1'b0, 8'h43, '0, ST_DONE, 1'b0, 1'b0, "R7 status idle");

        // R2: write-mode command, no launch
        c1 = mkcmd(1'b0, 7'd2, 32'h1000_0003);
        access(1'b1, 8'h41, c1, 64'h0, 1'b0, 1'b0, "R2 cmd write");
        access(1'b0, 8'h41, '0, c1, 1'b0, 1'b0, "R2 cmd readback");

        // R5: data write launches a downstream write, lane offset 3
        expect_dn(1'b1, 32'h1000_0003, 7'd2, 64'h4455_6677_8800_0000, '0, 4'd3, "R5 dn write");
        access(1'b1, 8'h42, D1, 64'h0, 1'b0, 1'b1, "R5 data write");
        access(1'b0, 8'h42, '0, D1, 1'b0, 1'b0, "R5 data readback");

        // R3/R4: read offset 5 size 1, other lanes cleared
        c2 = mkcmd(1'b1, 7'd1, 32'h0000_2005);
        expect_dn(1'b0, 32'h0000_2005, 7'd1, '0, RAW, 4'd2, "R3 dn read");
        access(1'b1, 8'h41, c2, 64'h0, 1'b0, 1'b1, "R3 read launch");
        access(1'b0, 8'h42, '0, place(RAW, 5, 1), 1'b0, 1'b0, "R4 lane 5 size 1");
        check(place(RAW, 5, 1) == 64'h0000_0000_00A1_0000, "R4 model", place(RAW, 5, 1),
              64'h0000_0000_00A1_0000);

        // R4: size runs past the sector end, clipped; zero-latency ack (R10)
        c3 = mkcmd(1'b1, 7'd4, 32'h0000_300E);
        expect_dn(1'b0, 32'h0000_300E, 7'd4, '0, RAW, 4'd0, "R10 dn read zero latency");
        access(1'b1, 8'h41, c3, 64'h0, 1'b0, 1'b1, "R10 read launch");
        access(1'b0, 8'h42, '0, 64'h0000_0000_0000_A1B2, 1'b0, 1'b0, "R4 clipped lanes 6-7");

        // R4: full doubleword at offset 0
        c4 = mkcmd(1'b1, 7'd8, 32'h0000_4000);
        expect_dn(1'b0, 32'h0000_4000, 7'd8, '0, RAW, 4'd5, "R3 dn read full");
        access(1'b1, 8'h41, c4, 64'h0, 1'b0, 1'b1, "R3 full read launch");
        access(1'b0, 8'h42, '0, RAW, 1'b0, 1'b0, "R4 full doubleword");

        // R6: data write while read flag set
        access(1'b1, 8'h42, D2, 64'h0, 1'b0, 1'b0, "R6 data write read-mode");
        access(1'b0, 8'h42, '0, D2, 1'b0, 1'b0, "R6 data readback");

        // R7/R8: status and silent offsets discard writes
        access(1'b1, 8'h43, 64'h0, 64'h0, 1'b0, 1'b0, "R7 status write");
        access(1'b0, 8'h43, '0, ST_DONE, 1'b0, 1'b0, "R7 status unchanged");
        access(1'b1, 8'h40, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 1'b0, "R8 base write");
        access(1'b0, 8'h40, '0, 64'h0, 1'b0, 1'b0, "R8 base read");
        access(1'b1, 8'h12, 64'h1234, 64'h0, 1'b0, 1'b0, "R8 log write");
        access(1'b0, 8'h12, '0, 64'h0, 1'b0, 1'b0, "R8 log read");
        access(1'b0, 8'h13, '0, 64'h0, 1'b0, 1'b0, "R8 err read");
        access(1'b0, 8'h18, '0, 64'h0, 1'b0, 1'b0, "R8 rx status read");
        access(1'b0, 8'h41, '0, c4, 1'b0, 1'b0, "R8 cmd unchanged");
        access(1'b0, 8'h42, '0, D2, 1'b0, 1'b0, "R8 data unchanged");

        // R9: unmapped offsets
        access(1'b1, 8'h77, 64'hCAFE, 64'h0, 1'b1, 1'b0, "R9 unmapped write");
        access(1'b0, 8'h77, '0, 64'h0, 1'b1, 1'b0, "R9 unmapped read");
        access(1'b0, 8'h44, '0, 64'h0, 1'b1, 1'b0, "R9 neighbour unmapped read");
        access(1'b0, 8'h42, '0, D2, 1'b0, 1'b0, "R9 data unchanged");

        // R5: full-width write at offset 0, zero latency
        c5 = mkcmd(1'b0, 7'd8, 32'h0000_5000);
        access(1'b1, 8'h41, c5, 64'h0, 1'b0, 1'b0, "R2 write-mode cmd");
        expect_dn(1'b1, 32'h0000_5000, 7'd8, D1, '0, 4'd0, "R5 dn write full");
        access(1'b1, 8'h42, D1, 64'h0, 1'b0, 1'b1, "R5 full write");
        access(1'b0, 8'h43, '0, ST_DONE, 1'b0, 1'b0, "R7 status after write");

        repeat (3) @(negedge clk);
        check(dn_q.size() == 0, "R3 all downstream items seen", 64'(dn_q.size()), 64'h0);
        check(!busy, "R7 idle at end", {63'h0, busy}, 64'h0);
        finish_run();
    end
endmodule